// File: doc/BRIEF.md
# Simultaneous-Sample Conversion Sequencer

This block is the digital control core of a multichannel sampling converter. A conversion-start strobe, which may come from another clock domain, passes through a synchronizer. Its rising edge then launches one conversion group. The group is chosen by a two-bit mode select and holds two, three or four channel slots. The block holds every selected channel's input word at the moment the group is accepted. It then walks the slots in ascending register-address order and spends a fixed number of clocks on each slot. During the whole group it drives an active-low busy output.

A two-bit auxiliary select picks which of four auxiliary inputs feeds the aux slot. Result registers are double-buffered. The words captured at the start move into the four readable result registers together, on the clock edge where busy returns high. Until then the previous results stay readable. Registers outside the selected group keep their contents. The analog front end and the successive-approximation loop sit outside the block. Each channel's 11-bit result arrives on a digital input port.

Top module: `simsamp_seq`

## Requirements
- R1: `start_in` is passed through a two-flop synchronizer and an edge detector. `busy_n` goes low after the third rising clock edge at which `start_in` is sampled high, counting from the first such edge. The strobe must stay high for at least two clocks.
- R2: `busy_n` stays low for exactly n × CYC_PER_CH clocks, where n is the group size (2, 3 or 4) and CYC_PER_CH defaults to 40.
- R3: `mode`, latched when a group is accepted, chooses the group, given as register addresses:
  - 00 → {1,2}
  - 01 → {1,2,3}
  - 10 → {0,1,2}
  - 11 → {0,1,2,3}
- R4: While busy, `cur_ch` shows the address of the slot in conversion. It starts at the group's lowest address and steps up by one every CYC_PER_CH clocks. While idle it reads 0.
- R5: Channel words are captured at group acceptance, so later input changes have no effect. The previous results stay readable through the last busy cycle. All selected registers update together on the edge where `busy_n` rises.
- R6: Result registers outside the selected group keep their previous contents.
- R7: `aux_sel`, latched at acceptance, picks which auxiliary input word (0 to 3, in binary order from `aux_d` bit 0 upward, 11 bits each) feeds the aux slot.
- R8: A rising `start_in` that arrives while `busy_n` is low is ignored. It neither restarts nor extends the group, and it does not launch a new group afterwards.
- R9: With `rst_n` low, all result registers clear to zero, `busy_n` is high and `cur_ch` is 0.
- R10: `rd_addr` selects a register: 0 = vin1, 1 = vin2, 2 = vin3, 3 = aux. `rd_data` is combinational and shows that register's 11-bit result in bits 11:1, with bit 0 always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_in | input | 1 | Conversion-start strobe, may be asynchronous |
| mode | input | 2 | Group select |
| aux_sel | input | 2 | Auxiliary input select |
| vin1_d | input | 11 | Channel 1 result word |
| vin2_d | input | 11 | Channel 2 result word |
| vin3_d | input | 11 | Channel 3 result word |
| aux_d | input | 44 | Four packed auxiliary result words |
| rd_addr | input | 2 | Result register address |
| rd_data | output | 12 | Left-justified result read-out |
| busy_n | output | 1 | Low while a group is in conversion |
| cur_ch | output | 2 | Address of the slot being converted |

## Verification
The bench runs every combination of the four modes and the four auxiliary selects as separate groups. Each group carries new input words computed from its index. This tells apart group membership, aux steering and the preservation of registers outside the group. During each group the bench scrambles the input words, the mode and the aux select. Any capture or latching that happens later than acceptance then shows up as wrong data or wrong timing. Some groups also receive a second start pulse mid-conversion, to separate an ignored strobe from a restarted or chained group. A reset during a group shows that busy and the registers return to their idle values.

// File: rtl/simsamp_pkg.sv
package simsamp_pkg;

   typedef logic [1:0] slot_t;

   localparam int unsigned NUM_SLOTS = 4;

   function automatic slot_t grp_first(input logic [1:0] m);
      return m[1] ? 2'd0 : 2'd1;
   endfunction

   function automatic slot_t grp_last(input logic [1:0] m);
      return m[0] ? 2'd3 : 2'd2;
   endfunction

   function automatic int unsigned grp_len(input logic [1:0] m);
      return 32'(grp_last(m)) - 32'(grp_first(m)) + 1;
   endfunction

   function automatic logic in_grp(input logic [1:0] m, input int unsigned k);
      return (k >= 32'(grp_first(m))) && (k <= 32'(grp_last(m)));
   endfunction

endpackage

// File: rtl/simsamp_edge.sv
module simsamp_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("simsamp_edge: STAGES must be at least 2");
   end

   logic [STAGES:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], din};
   end

   assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/simsamp_ctrl.sv
module simsamp_ctrl
   import simsamp_pkg::*;
#(
   parameter int unsigned CYC = 40
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  go,
   input  logic [1:0] mode,
   output logic  accept,
   output logic  finish,
   output logic  busy,
   output slot_t slot
);
   if (CYC < 2) begin : g_bad_cyc
      $error("simsamp_ctrl: CYC must be at least 2");
   end

   localparam int unsigned CNT_W = $clog2(CYC);
   localparam logic [CNT_W-1:0] CYC_LAST = CNT_W'(CYC - 1);

   logic [CNT_W-1:0] cyc;
   slot_t            last_q;

   assign accept = go & ~busy;
   assign finish = busy && (slot == last_q) && (cyc == CYC_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cyc    <= '0;
         slot   <= '0;
         last_q <= '0;
      end else if (accept) begin
         busy   <= 1'b1;
         cyc    <= '0;
         slot   <= grp_first(mode);
         last_q <= grp_last(mode);
      end else if (busy) begin
         if (cyc == CYC_LAST) begin
            cyc <= '0;
            if (slot == last_q) begin
               busy <= 1'b0;
               slot <= '0;
            end else begin
               slot <= slot + 2'd1;
            end
         end else begin
            cyc <= cyc + 1'b1;
         end
      end
   end
endmodule

// File: rtl/simsamp_bank.sv
module simsamp_bank
   import simsamp_pkg::*;
#(
   parameter int unsigned W    = 11,
   parameter int unsigned NAUX = 4,
   localparam int unsigned SEL_W = (NAUX > 1) ? $clog2(NAUX) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                accept,
   input  logic                finish,
   input  logic [1:0]          mode,
   input  logic [SEL_W-1:0]    aux_sel,
   input  logic [W-1:0]        vin1_d,
   input  logic [W-1:0]        vin2_d,
   input  logic [W-1:0]        vin3_d,
   input  logic [NAUX*W-1:0]   aux_d,
   input  slot_t               rd_addr,
   output logic [W:0]          rd_data,
   output logic [NUM_SLOTS*W-1:0] res_flat
);
   if (NAUX < 2) begin : g_bad_naux
      $error("simsamp_bank: NAUX must be at least 2");
   end
   if (W < 2) begin : g_bad_w
      $error("simsamp_bank: W must be at least 2");
   end

   logic [W-1:0] in_vec [NUM_SLOTS];
   logic [W-1:0] smp    [NUM_SLOTS];
   logic [W-1:0] res    [NUM_SLOTS];
   logic [1:0]   mode_q;

   assign in_vec[0] = vin1_d;
   assign in_vec[1] = vin2_d;
   assign in_vec[2] = vin3_d;
   assign in_vec[3] = aux_d[aux_sel*W +: W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mode_q <= '0;
      else if (accept) mode_q <= mode;
   end

   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            smp[k] <= '0;
            res[k] <= '0;
         end else begin
            if (accept) smp[k] <= in_vec[k];
            if (finish && in_grp(mode_q, k)) res[k] <= smp[k];
         end
      end
      assign res_flat[k*W +: W] = res[k];
   end

   assign rd_data = {res[rd_addr], 1'b0};
endmodule

// File: rtl/simsamp_seq.sv
module simsamp_seq
   import simsamp_pkg::*;
#(
   parameter int unsigned DATA_W     = 11,
   parameter int unsigned CYC_PER_CH = 40,
   parameter int unsigned SYNC_STG   = 2,
   parameter int unsigned NAUX       = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_in,
   input  logic [1:0]             mode,
   input  logic [1:0]             aux_sel,
   input  logic [DATA_W-1:0]      vin1_d,
   input  logic [DATA_W-1:0]      vin2_d,
   input  logic [DATA_W-1:0]      vin3_d,
   input  logic [NAUX*DATA_W-1:0] aux_d,
   input  logic [1:0]             rd_addr,
   output logic [DATA_W:0]        rd_data,
   output logic                   busy_n,
   output logic [1:0]             cur_ch
);
   if (NAUX != 4) begin : g_bad_aux
      $error("simsamp_seq: aux_sel port is two bits, NAUX must be 4");
   end

   logic  go, accept, finish, busy;
   slot_t slot;
   logic [NUM_SLOTS*DATA_W-1:0] res_flat;

   simsamp_edge #(.STAGES(SYNC_STG)) u_edge (
      .clk(clk), .rst_n(rst_n), .din(start_in), .rise(go)
   );

   simsamp_ctrl #(.CYC(CYC_PER_CH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .go(go), .mode(mode),
      .accept(accept), .finish(finish), .busy(busy), .slot(slot)
   );

   simsamp_bank #(.W(DATA_W), .NAUX(NAUX)) u_bank (
      .clk(clk), .rst_n(rst_n), .accept(accept), .finish(finish),
      .mode(mode), .aux_sel(aux_sel),
      .vin1_d(vin1_d), .vin2_d(vin2_d), .vin3_d(vin3_d), .aux_d(aux_d),
      .rd_addr(rd_addr), .rd_data(rd_data), .res_flat(res_flat)
   );

   assign busy_n = ~busy;
   assign cur_ch = slot;
endmodule

// File: rtl/simsamp_seq_chk.sv
module simsamp_seq_chk
   import simsamp_pkg::*;
#(
   parameter int unsigned W   = 11,
   parameter int unsigned CYC = 40
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     start_in,
   input logic [1:0]               mode,
   input logic                     busy_n,
   input logic [1:0]               cur_ch,
   input logic [NUM_SLOTS*W-1:0]   res_flat
);
   logic [1:0]  mode_d;
   logic        busy_n_d;
   logic [15:0] low_cnt;
   logic [15:0] exp_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_d   <= '0;
         busy_n_d <= 1'b1;
         low_cnt  <= '0;
         exp_len  <= '0;
      end else begin
         mode_d   <= mode;
         busy_n_d <= busy_n;
         low_cnt  <= busy_n ? 16'd0 : low_cnt + 16'd1;
         if (busy_n_d && !busy_n) exp_len <= 16'(grp_len(mode_d) * CYC);
      end
   end

   // R2: busy low window has the group's exact length
   a_r2_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_n) |-> low_cnt == exp_len);

   // R1: a group starts only after start was seen through the synchronizer
   a_r1_sync_start: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_n) |-> $past(start_in, 3));

   // R5: results change only on the edge where busy rises
   a_r5_buffered: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(busy_n) |-> $stable(res_flat));

   // R8: no restart inside a group, slot index never moves backwards
   a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_n && $past(!busy_n)) |-> cur_ch >= $past(cur_ch));

   // R4: idle slot indicator is zero
   a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      busy_n |-> cur_ch == 2'd0);
endmodule

bind simsamp_seq simsamp_seq_chk #(.W(DATA_W), .CYC(CYC_PER_CH)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_in(start_in), .mode(mode),
   .busy_n(busy_n), .cur_ch(cur_ch), .res_flat(res_flat)
);

// File: tb/simsamp_seq_test.sv
module simsamp_seq_test;
   localparam int W   = 11;
   localparam int CYC = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_in = 1'b0;
   logic [1:0] mode = '0, aux_sel = '0, rd_addr = '0;
   logic [W-1:0] vin1_d = '0, vin2_d = '0, vin3_d = '0;
   logic [4*W-1:0] aux_d = '0;
   logic [W:0] rd_data;
   logic busy_n;
   logic [1:0] cur_ch;

   int vectors = 0, errors = 0;
   bit done = 1'b0;
   logic [W-1:0] model [4];

   always #4 clk = ~clk;

   simsamp_seq uut (
      .clk(clk), .rst_n(rst_n), .start_in(start_in), .mode(mode),
      .aux_sel(aux_sel), .vin1_d(vin1_d), .vin2_d(vin2_d), .vin3_d(vin3_d),
      .aux_d(aux_d), .rd_addr(rd_addr), .rd_data(rd_data),
      .busy_n(busy_n), .cur_ch(cur_ch)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] word(input int i, input int ch);
      return W'((i * 97 + ch * 331 + 17) % 2048);
   endfunction

   task automatic read_all(input string req, input logic [W-1:0] e [4]);
      for (int a = 0; a < 4; a++) begin
         rd_addr = 2'(a);
         #1;
         chk(req, rd_data, {e[a], 1'b0});
      end
   endtask

   task automatic run_grp(input int i, input logic [1:0] m,
                          input logic [1:0] s, input bit extra_start);
      int first, last, n, k;
      logic [W-1:0] old [4];
      first = m[1] ? 0 : 1;
      last  = m[0] ? 3 : 2;
      n     = last - first + 1;
      for (int a = 0; a < 4; a++) old[a] = model[a];
      @(negedge clk);
      vin1_d = word(i, 0); vin2_d = word(i, 1); vin3_d = word(i, 2);
      for (int j = 0; j < 4; j++) aux_d[j*W +: W] = word(i, 3 + j);
      mode = m; aux_sel = s; start_in = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk("R1 busy still high", busy_n, 1);
      @(posedge clk); @(negedge clk);
      chk("R1 busy low", busy_n, 0);
      // R5 R3 R7: scramble inputs and selects after acceptance
      start_in = 1'b0;
      vin1_d = ~vin1_d; vin2_d = ~vin2_d; vin3_d = ~vin3_d; aux_d = ~aux_d;
      mode = m + 2'd1; aux_sel = s + 2'd1;
      k = 0;
      while (busy_n == 1'b0 && k < 400) begin
         chk("R4 cur_ch", cur_ch, first + k / CYC);
         if (k == n * CYC - 1) read_all("R5 old data", old);
         if (extra_start && k == 30) start_in = 1'b1;
         if (extra_start && k == 34) start_in = 1'b0;
         k++;
         @(negedge clk);
      end
      chk("R2 busy length", k, n * CYC);
      chk("R4 idle cur_ch", cur_ch, 0);
      for (int a = 0; a < 4; a++)
         if (a >= first && a <= last)
            model[a] = (a == 3) ? word(i, 3 + s) : word(i, a);
      read_all("R3 R6 R7 R10 new data", model);
      if (extra_start) begin
         repeat (12) begin
            @(negedge clk);
            chk("R8 start ignored", busy_n, 1);
         end
      end
   endtask

   initial begin
      for (int a = 0; a < 4; a++) model[a] = '0;
      repeat (3) @(negedge clk);
      chk("R9 reset busy", busy_n, 1);
      chk("R9 reset cur_ch", cur_ch, 0);
      read_all("R9 reset regs", model);
      rst_n = 1'b1;
      for (int g = 0; g < 16; g++)
         run_grp(g, 2'(g % 4), 2'(g / 4), (g % 5) == 2);
      // R9: reset in the middle of a group
      @(negedge clk);
      mode = 2'b11; start_in = 1'b1;
      repeat (10) @(negedge clk);
      start_in = 1'b0;
      rst_n = 1'b0;
      #1;
      chk("R9 mid reset busy", busy_n, 1);
      for (int a = 0; a < 4; a++) model[a] = '0;
      read_all("R9 mid reset regs", model);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         vectors++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule